// File: doc/BRIEF.md
# DMA Channel Control Register Block

This block holds the software-visible control state of a multi-channel DMA layer that serves up to 32 transmit and 32 receive channels. A simple register port, with separate read and write strobes, reaches a configuration word, an error status word, an interrupt enable mask and a pair of set/clear registers for channel activity in each direction. The same port also reaches four interrupt status words and three per-channel arrays: transmit descriptor pointers, receive descriptor pointers and receive buffer sizes. The data engine itself lives elsewhere. It raises per-channel event strobes that set the status bits, and it consumes the stored pointers and sizes.

Software clears any status bit by writing a 1 to it. Writing the configuration register with its top bit set returns every control and status register to its reset value. The descriptor arrays keep their contents. Five registered interrupt lines each report whether an enabled status word has any bit set. Read data comes back one cycle after the read strobe and holds until the next read.

Top module: `dma_chan_regs`

## Requirements
- R1: After reset the configuration register reads 0x0007C000. The error status, interrupt enable, channel-active and all four interrupt status registers read 0, and `irq` is 0.
- R2: A write to the configuration register (0x180) with bit 31 clear stores the written value ANDed with 0x00FFC087.
- R3: A write to the configuration register with bit 31 set returns every register of R1 to its reset value. The pointer and size arrays keep their contents, and `irq` is 0 two cycles later.
- R4: The interrupt enable register (0x182) keeps only bits 4:0 of a write. The other bits read 0.
- R5: Writing 0x184 (transmit) or 0x190 (receive) ORs the written bits into the channel-active mask. Writing 0x185 or 0x191 clears the bits written as 1. The transmit mask keeps only bits 31:28 and the receive mask keeps only bits 31:30. Both addresses of a pair read the mask.
- R6: A channel's bit n in the transmit end-of-buffer (0x186), receive end-of-buffer (0x192), transmit descriptor-error (0x188) or receive descriptor-error (0x193) status register is set by the matching event strobe bit n. It is cleared by a write of 1 to bit n. If an event and a clear land in the same cycle, the bit stays set.
- R7: Error status (0x181, ERR_W bits) bits are set by `err_ev` and cleared by writing 1 to them.
- R8: Transmit pointer n sits at 0x1A0+n and receive pointer n at 0x1C0+n, for n below TX_CH or RX_CH. Each holds all 32 written bits.
- R9: Receive buffer size n sits at 0x1E0+n for n below RX_CH and keeps only bits 7:0.
- R10: Any other address, including the first address past each channel window, reads 0, and writes to it change nothing.
- R11: Bit k of `irq` is the OR of status word k ANDed with enable bit k, one cycle after the status. The order of k is 0 error, 1 transmit end-of-buffer, 2 receive end-of-buffer, 3 transmit descriptor-error and 4 receive descriptor-error.
- R12: `rdata` presents the value addressed in a read one cycle after `rd_en`. It does not change in a cycle without `rd_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | ADDR_W | Register address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, one cycle after rd_en |
| txeob_ev | input | TX_CH | Transmit end-of-buffer events, one per channel |
| rxeob_ev | input | RX_CH | Receive end-of-buffer events, one per channel |
| txde_ev | input | TX_CH | Transmit descriptor-error events |
| rxde_ev | input | RX_CH | Receive descriptor-error events |
| err_ev | input | ERR_W | Error status set events |
| irq | output | 5 | Masked interrupt lines, order per R11 |

## Verification
The assertions assume that `rd_en` and `wr_en` are never raised while reset is held. They also assume that no register write falls in the cycle directly after a write that zeroes the enable mask or triggers a soft reset, so that the mask cannot be re-armed before the interrupt lines drop. The stimulus drives each strobe for one cycle and releases it at the next falling edge, with reads and writes in separate cycles. Event strobes are pulsed the same way, except for one deliberate overlap of an event with a clear of the same bit.

// File: rtl/dmareg_pkg.sv
package dmareg_pkg;
  localparam int DATA_W   = 32;
  localparam int IDX_MAX  = 32;
  localparam int IRQ_N    = 5;

  localparam int A_CFG    = 'h180;
  localparam int A_ESR    = 'h181;
  localparam int A_IER    = 'h182;
  localparam int A_TXSET  = 'h184;
  localparam int A_TXCLR  = 'h185;
  localparam int A_TXEOB  = 'h186;
  localparam int A_TXDE   = 'h188;
  localparam int A_RXSET  = 'h190;
  localparam int A_RXCLR  = 'h191;
  localparam int A_RXEOB  = 'h192;
  localparam int A_RXDE   = 'h193;
  localparam int A_TXPTR  = 'h1A0;
  localparam int A_RXPTR  = 'h1C0;
  localparam int A_RXSZ   = 'h1E0;

  localparam logic [DATA_W-1:0] CFG_RST   = 32'h0007_C000;
  localparam logic [DATA_W-1:0] CFG_KEEP  = 32'h00FF_C087;
  localparam logic [DATA_W-1:0] TXA_KEEP  = 32'hF000_0000;
  localparam logic [DATA_W-1:0] RXA_KEEP  = 32'hC000_0000;

  typedef enum logic [1:0] {
    SRC_REG,
    SRC_TXP,
    SRC_RXP,
    SRC_RXS
  } rd_src_e;
endpackage

// File: rtl/dmareg_w1c.sv
module dmareg_w1c #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr_all,
  input  logic [W-1:0] set_i,
  input  logic         clr_we,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] q
);
  logic [W-1:0] clr_mask;
  assign clr_mask = clr_we ? clr_i : '0;

  always_ff @(posedge clk) begin
    if (rst || clr_all) q <= '0;
    else                q <= (q & ~clr_mask) | set_i;
  end
endmodule

// File: rtl/dmareg_chan_mem.sv
module dmareg_chan_mem #(
  parameter int DEPTH = 4,
  parameter int W     = 32,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
  import dmareg_pkg::*;
#(
  parameter int TX_CH  = 4,
  parameter int RX_CH  = 2,
  parameter int ERR_W  = 8,
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  input  logic [TX_CH-1:0]  txeob_ev,
  input  logic [RX_CH-1:0]  rxeob_ev,
  input  logic [TX_CH-1:0]  txde_ev,
  input  logic [RX_CH-1:0]  rxde_ev,
  input  logic [ERR_W-1:0]  err_ev,
  output logic [4:0]        irq
);
  localparam int TX_AW = (TX_CH > 1) ? $clog2(TX_CH) : 1;
  localparam int RX_AW = (RX_CH > 1) ? $clog2(RX_CH) : 1;

  // address decode
  logic hit_txp, hit_rxp, hit_rxs;
  logic [TX_AW-1:0] txp_idx;
  logic [RX_AW-1:0] rxp_idx, rxs_idx;

  assign hit_txp = (addr >= ADDR_W'(A_TXPTR)) && (addr < ADDR_W'(A_TXPTR + TX_CH));
  assign hit_rxp = (addr >= ADDR_W'(A_RXPTR)) && (addr < ADDR_W'(A_RXPTR + RX_CH));
  assign hit_rxs = (addr >= ADDR_W'(A_RXSZ))  && (addr < ADDR_W'(A_RXSZ + RX_CH));
  assign txp_idx = TX_AW'(addr - ADDR_W'(A_TXPTR));
  assign rxp_idx = RX_AW'(addr - ADDR_W'(A_RXPTR));
  assign rxs_idx = RX_AW'(addr - ADDR_W'(A_RXSZ));

  function automatic logic wr_at(input logic we, input logic [ADDR_W-1:0] a, input int tgt);
    return we && (a == ADDR_W'(tgt));
  endfunction

  logic soft_rst;
  assign soft_rst = wr_at(wr_en, addr, A_CFG) && wdata[31];

  // control registers
  logic [31:0] cfg_q, txact_q, rxact_q;
  logic [4:0]  ier_q;

  always_ff @(posedge clk) begin
    if (rst || soft_rst) begin
      cfg_q   <= CFG_RST;
      ier_q   <= '0;
      txact_q <= '0;
      rxact_q <= '0;
    end else if (wr_en) begin
      if (addr == ADDR_W'(A_CFG))   cfg_q   <= wdata & CFG_KEEP;
      if (addr == ADDR_W'(A_IER))   ier_q   <= wdata[4:0];
      if (addr == ADDR_W'(A_TXSET)) txact_q <= txact_q | (wdata & TXA_KEEP);
      if (addr == ADDR_W'(A_TXCLR)) txact_q <= txact_q & ~(wdata & TXA_KEEP);
      if (addr == ADDR_W'(A_RXSET)) rxact_q <= rxact_q | (wdata & RXA_KEEP);
      if (addr == ADDR_W'(A_RXCLR)) rxact_q <= rxact_q & ~(wdata & RXA_KEEP);
    end
  end

  // write-one-to-clear status words
  logic [ERR_W-1:0] esr_q;
  logic [TX_CH-1:0] txeob_q, txde_q;
  logic [RX_CH-1:0] rxeob_q, rxde_q;

  dmareg_w1c #(.W(ERR_W)) u_esr (
    .clk(clk), .rst(rst), .clr_all(soft_rst), .set_i(err_ev),
    .clr_we(wr_at(wr_en, addr, A_ESR)), .clr_i(wdata[ERR_W-1:0]), .q(esr_q));
  dmareg_w1c #(.W(TX_CH)) u_txeob (
    .clk(clk), .rst(rst), .clr_all(soft_rst), .set_i(txeob_ev),
    .clr_we(wr_at(wr_en, addr, A_TXEOB)), .clr_i(wdata[TX_CH-1:0]), .q(txeob_q));
  dmareg_w1c #(.W(RX_CH)) u_rxeob (
    .clk(clk), .rst(rst), .clr_all(soft_rst), .set_i(rxeob_ev),
    .clr_we(wr_at(wr_en, addr, A_RXEOB)), .clr_i(wdata[RX_CH-1:0]), .q(rxeob_q));
  dmareg_w1c #(.W(TX_CH)) u_txde (
    .clk(clk), .rst(rst), .clr_all(soft_rst), .set_i(txde_ev),
    .clr_we(wr_at(wr_en, addr, A_TXDE)), .clr_i(wdata[TX_CH-1:0]), .q(txde_q));
  dmareg_w1c #(.W(RX_CH)) u_rxde (
    .clk(clk), .rst(rst), .clr_all(soft_rst), .set_i(rxde_ev),
    .clr_we(wr_at(wr_en, addr, A_RXDE)), .clr_i(wdata[RX_CH-1:0]), .q(rxde_q));

  // per-channel arrays (no reset, RAM-friendly)
  logic [31:0] txp_rd, rxp_rd;
  logic [7:0]  rxs_rd;

  dmareg_chan_mem #(.DEPTH(TX_CH), .W(32)) u_txptr (
    .clk(clk), .we(wr_en && hit_txp), .waddr(txp_idx), .wdata(wdata),
    .re(rd_en && hit_txp), .raddr(txp_idx), .rdata(txp_rd));
  dmareg_chan_mem #(.DEPTH(RX_CH), .W(32)) u_rxptr (
    .clk(clk), .we(wr_en && hit_rxp), .waddr(rxp_idx), .wdata(wdata),
    .re(rd_en && hit_rxp), .raddr(rxp_idx), .rdata(rxp_rd));
  dmareg_chan_mem #(.DEPTH(RX_CH), .W(8)) u_rxsize (
    .clk(clk), .we(wr_en && hit_rxs), .waddr(rxs_idx), .wdata(wdata[7:0]),
    .re(rd_en && hit_rxs), .raddr(rxs_idx), .rdata(rxs_rd));

  // read path
  logic [31:0] reg_val, reg_rd_q;
  rd_src_e     src_d, src_q;

  always_comb begin
    reg_val = '0;
    unique case (addr)
      ADDR_W'(A_CFG):   reg_val = cfg_q;
      ADDR_W'(A_ESR):   reg_val = 32'(esr_q);
      ADDR_W'(A_IER):   reg_val = 32'(ier_q);
      ADDR_W'(A_TXSET),
      ADDR_W'(A_TXCLR): reg_val = txact_q;
      ADDR_W'(A_RXSET),
      ADDR_W'(A_RXCLR): reg_val = rxact_q;
      ADDR_W'(A_TXEOB): reg_val = 32'(txeob_q);
      ADDR_W'(A_TXDE):  reg_val = 32'(txde_q);
      ADDR_W'(A_RXEOB): reg_val = 32'(rxeob_q);
      ADDR_W'(A_RXDE):  reg_val = 32'(rxde_q);
      default:          reg_val = '0;
    endcase
    if (hit_txp)      src_d = SRC_TXP;
    else if (hit_rxp) src_d = SRC_RXP;
    else if (hit_rxs) src_d = SRC_RXS;
    else              src_d = SRC_REG;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rd_q <= '0;
      src_q    <= SRC_REG;
    end else if (rd_en) begin
      reg_rd_q <= reg_val;
      src_q    <= src_d;
    end
  end

  always_comb begin
    unique case (src_q)
      SRC_TXP: rdata = txp_rd;
      SRC_RXP: rdata = rxp_rd;
      SRC_RXS: rdata = 32'(rxs_rd);
      default: rdata = reg_rd_q;
    endcase
  end

  // interrupt lines
  always_ff @(posedge clk) begin
    if (rst) irq <= '0;
    else begin
      irq[0] <= (|esr_q)   & ier_q[0];
      irq[1] <= (|txeob_q) & ier_q[1];
      irq[2] <= (|rxeob_q) & ier_q[2];
      irq[3] <= (|txde_q)  & ier_q[3];
      irq[4] <= (|rxde_q)  & ier_q[4];
    end
  end
endmodule

// File: rtl/dma_chan_regs_chk.sv
module dma_chan_regs_chk
  import dmareg_pkg::*;
#(
  parameter int RX_CH  = 2,
  parameter int ADDR_W = 10
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic              rd_en,
  input logic [ADDR_W-1:0] addr,
  input logic [31:0]       wdata,
  input logic [31:0]       rdata,
  input logic [4:0]        irq
);
  // R1
  irq_reset_chk: assert property (@(posedge clk) rst |=> irq == 5'd0);

  // R12
  rdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rdata));

  // R10
  unmapped_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_en && addr == {ADDR_W{1'b1}}) |=> rdata == 32'd0);

  // R9
  rxsize_width_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_en && addr >= ADDR_W'(A_RXSZ) && addr < ADDR_W'(A_RXSZ + RX_CH))
      |=> rdata[31:8] == 24'd0);

  // R5
  txact_width_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_en && addr == ADDR_W'(A_TXSET)) |=> rdata[27:0] == 28'd0);

  // R11
  mask_off_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == ADDR_W'(A_IER) && wdata[4:0] == 5'd0) |=> ##1 irq == 5'd0);

  // R3
  soft_reset_irq_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == ADDR_W'(A_CFG) && wdata[31]) |=> ##1 irq == 5'd0);
endmodule

bind dma_chan_regs dma_chan_regs_chk #(.RX_CH(RX_CH), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
  .wdata(wdata), .rdata(rdata), .irq(irq));

// File: tb/tb_dma_chan_regs.sv
module tb_dma_chan_regs;
  localparam int TX_CH = 4, RX_CH = 2, ERR_W = 8, ADDR_W = 10;

  logic clk = 0, rst = 1, wr_en = 0, rd_en = 0;
  logic [ADDR_W-1:0] addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic [TX_CH-1:0] txeob_ev = '0, txde_ev = '0;
  logic [RX_CH-1:0] rxeob_ev = '0, rxde_ev = '0;
  logic [ERR_W-1:0] err_ev = '0;
  logic [4:0] irq;

  int checks = 0, errors = 0;
  logic [31:0] exp_q[$];
  string tag_q[$];
  logic rd_q = 0;

  always #2 clk = ~clk;

  dma_chan_regs #(.TX_CH(TX_CH), .RX_CH(RX_CH), .ERR_W(ERR_W), .ADDR_W(ADDR_W)) dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .txeob_ev(txeob_ev), .rxeob_ev(rxeob_ev), .txde_ev(txde_ev),
    .rxde_ev(rxde_ev), .err_ev(err_ev), .irq(irq));

  // monitor: compare each read result one cycle after its strobe
  always @(posedge clk) rd_q <= rd_en;
  always @(negedge clk) begin
    if (rd_q) begin
      logic [31:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if (rdata !== e) begin
        errors++;
        $display("FAIL %s: rdata=%h expected=%h", t, rdata, e);
      end
    end
  end

  task automatic wr(input int a, input logic [31:0] d);
    addr = ADDR_W'(a); wdata = d; wr_en = 1;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(input int a, input logic [31:0] e, input string t);
    addr = ADDR_W'(a); rd_en = 1;
    exp_q.push_back(e); tag_q.push_back(t);
    @(negedge clk); rd_en = 0;
  endtask

  task automatic settle();
    @(negedge clk);
  endtask

  task automatic chk_irq(input logic [4:0] e, input string t);
    checks++;
    if (irq !== e) begin
      errors++;
      $display("FAIL %s: irq=%b expected=%b", t, irq, e);
    end
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog: run=hung expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    // R1 reset state
    chk_irq(5'd0, "R1 irq");
    rd('h180, 32'h0007C000, "R1 cfg");
    rd('h181, 0, "R1 esr");
    rd('h182, 0, "R1 ier");
    rd('h184, 0, "R1 txact");
    rd('h190, 0, "R1 rxact");
    rd('h186, 0, "R1 txeob");
    rd('h192, 0, "R1 rxeob");
    rd('h188, 0, "R1 txde");
    rd('h193, 0, "R1 rxde");
    // R2 config masking
    wr('h180, 32'h7F0FFFFF);
    rd('h180, 32'h000FC087, "R2 cfg mask");
    // R4 enable width
    wr('h182, 32'hFFFFFFE0);
    rd('h182, 0, "R4 ier upper ignored");
    wr('h182, 32'hFFFFFFFF);
    rd('h182, 32'h1F, "R4 ier");
    // R5 channel-active set/clear
    wr('h184, 32'hFFFFFFFF);
    rd('h184, 32'hF0000000, "R5 tx set");
    wr('h185, 32'h30000000);
    rd('h185, 32'hC0000000, "R5 tx clr");
    wr('h190, 32'hFFFFFFFF);
    rd('h190, 32'hC0000000, "R5 rx set");
    wr('h191, 32'h80000000);
    rd('h191, 32'h40000000, "R5 rx clr");
    // R8 pointer windows
    for (int i = 0; i < TX_CH; i++) wr('h1A0 + i, 32'hA5000000 + i);
    for (int i = 0; i < RX_CH; i++) wr('h1C0 + i, 32'h5A000010 + i);
    for (int i = 0; i < TX_CH; i++) rd('h1A0 + i, 32'hA5000000 + i, "R8 tx ptr");
    for (int i = 0; i < RX_CH; i++) rd('h1C0 + i, 32'h5A000010 + i, "R8 rx ptr");
    // R9 buffer size width
    wr('h1E0, 32'h12345678);
    wr('h1E1, 32'hFFFFFF9C);
    rd('h1E0, 32'h78, "R9 size0");
    rd('h1E1, 32'h9C, "R9 size1");
    // R10 past-the-window and unmapped
    wr('h1A0 + TX_CH, 32'hDEADBEEF);
    rd('h1A0 + TX_CH, 0, "R10 tx window end");
    wr('h1E0 + RX_CH, 32'hDEADBEEF);
    rd('h1E0 + RX_CH, 0, "R10 size window end");
    wr('h3FF, 32'hFFFFFFFF);
    rd('h3FF, 0, "R10 unmapped");
    rd('h183, 0, "R10 hole");
    rd('h1A0, 32'hA5000000, "R10 ptr0 untouched");
    // R6 transmit end-of-buffer + R11
    txeob_ev = 4'b1010; settle(); txeob_ev = '0;
    settle();
    chk_irq(5'b00010, "R11 txeob irq");
    rd('h186, 32'hA, "R6 txeob set");
    wr('h186, 32'h2);
    rd('h186, 32'h8, "R6 txeob w1c");
    wr('h186, 32'h8);
    settle();
    chk_irq(5'b00000, "R11 txeob cleared");
    // R6 receive descriptor error
    rxde_ev = 2'b01; settle(); rxde_ev = '0;
    settle();
    chk_irq(5'b10000, "R11 rxde irq");
    rd('h193, 32'h1, "R6 rxde set");
    // R6 event and clear in the same cycle
    txde_ev = 4'b0100; addr = ADDR_W'('h188); wdata = 32'h4; wr_en = 1;
    settle(); txde_ev = '0; wr_en = 0;
    rd('h188, 32'h4, "R6 set wins over clear");
    rxeob_ev = 2'b10; settle(); rxeob_ev = '0;
    rd('h192, 32'h2, "R6 rxeob set");
    // R7 error status
    err_ev = 8'h81; settle(); err_ev = '0;
    rd('h181, 32'h81, "R7 esr set");
    wr('h181, 32'h01);
    rd('h181, 32'h80, "R7 esr w1c");
    chk_irq(5'b11101, "R11 all pending");
    // R11 masking
    wr('h182, 32'h8);
    settle();
    chk_irq(5'b01000, "R11 mask txde only");
    wr('h182, 32'h0);
    settle();
    chk_irq(5'b00000, "R11 mask none");
    // R3 soft reset
    wr('h182, 32'h1F);
    settle();
    chk_irq(5'b11101, "R3 pre soft reset");
    wr('h180, 32'h80000000);
    settle();
    chk_irq(5'b00000, "R3 irq after soft reset");
    rd('h180, 32'h0007C000, "R3 cfg");
    rd('h182, 0, "R3 ier");
    rd('h184, 0, "R3 txact");
    rd('h190, 0, "R3 rxact");
    rd('h181, 0, "R3 esr");
    rd('h188, 0, "R3 txde");
    rd('h192, 0, "R3 rxeob");
    rd('h193, 0, "R3 rxde");
    rd('h1C1, 32'h5A000011, "R3 ptr kept");
    rd('h1E1, 32'h9C, "R3 size kept");
    // R12 hold without read strobe
    repeat (3) settle();
    checks++;
    if (rdata !== 32'h9C) begin
      errors++;
      $display("FAIL R12: rdata=%h expected=%h", rdata, 32'h9C);
    end
    repeat (2) settle();
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL scoreboard: pending=%0d expected=0", exp_q.size());
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule